// File: doc/BRIEF.md
# Shift Register Line Sequencer

This block drives the six control lines of an external serial-in, parallel-out shift register that has an output buffer: serial data, shift clock, data clear, buffer load, buffer clear and enable. A host issues commands over a valid/ready handshake. The commands are write (a data word, a bit count and an auto-latch flag), clear data, clear buffer, load buffer, full clear, enable and disable. The block turns each command into a timed sequence of line levels. Every pulse stays high for a programmable number of clock cycles and then stays low for the same number of cycles. When the command ends, the block returns a status code for one cycle.

Per-line presence bits describe boards on which some lines are not wired. A command that needs a missing line does nothing and reports not-supported. Optional steps that need a missing line are skipped without error. A full clear falls back to other lines when its preferred lines are missing. Per-line inversion bits let a low-active pin be driven with the same logical levels. After reset the block runs a fixed start-up sequence on its own. Only after that sequence does it accept commands.

Top module: `srl_line_seq`

## Requirements
- R1: A write with bit count N (1..DATA_W) puts data bits N-1 down to 0 on the serial data line, most significant of those bits first. For example, 0x8D with N=4 gives 1,1,0,1.
- R2: Each written bit has three phases of P cycles each. In the first phase the data line carries the bit and the shift clock is low. In the second phase the shift clock is high. In the third phase the shift clock is low again. The data line does not change while the shift clock is high, and it keeps the last bit until the next write.
- R3: A write with bit count 0, on a board with data and shift clock present, drives no line and returns status 0.
- R4: A write with auto-latch set ends with one buffer-load pulse after the last bit. If the buffer-load line is absent, that pulse is skipped and the status is still 0.
- R5: A command whose required line is absent drives nothing and returns status 1 (not supported). The required lines are: data and shift clock for write, data clear for clear data, buffer clear for clear buffer, buffer load for load, and enable for enable/disable.
- R6: A full clear with the data-clear line present pulses data clear first. It then pulses buffer clear. If buffer clear is absent it pulses buffer load instead. If both are absent it shifts FILL_BITS (32) zero bits, or returns status 1 when data or shift clock is absent.
- R7: A full clear with the data-clear line absent shifts FILL_BITS zero bits and then pulses buffer load if that line is present. If data or shift clock is absent, it drives nothing and returns status 1.
- R8: Enable sets the enable line high and disable sets it low. The level holds until the next enable command. While the block is idle, no line changes.
- R9: Each pin equals its logical level XOR its inversion bit. An absent line stays at logical 0. Line bit positions in the presence and inversion masks are: 0 data, 1 shift clock, 2 data clear, 3 buffer load, 4 buffer clear, 5 enable.
- R10: The pulse length P is pulse_cyc_i sampled when a command is accepted, or at the start of the start-up sequence. A value of 0 counts as 1.
- R11: After reset, with ready low and no status, the block pulses data clear and then buffer clear, and then drives enable high. Each of these steps is taken only if its line is present.
- R12: Ready is low from the cycle after acceptance through the status cycle. Status valid is high for exactly one cycle, in the cycle after the last line phase. Ready returns on the next cycle.
- R13: Op codes are: 0 write, 1 clear data, 2 clear buffer, 3 load, 4 full clear, 5 enable, 6 disable. Op 7, or a write with bit count above DATA_W, drives nothing and returns status 2 (invalid).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command accepted when high together with valid |
| cmd_op_i | input | 3 | Op code (R13) |
| cmd_data_i | input | DATA_W | Write data |
| cmd_nbits_i | input | $clog2(DATA_W+1) | Write bit count |
| cmd_latch_i | input | 1 | Auto-latch after write |
| pulse_cyc_i | input | CW | Phase length in cycles, 0 read as 1 |
| line_present_i | input | 6 | Line presence mask (R9 positions) |
| line_invert_i | input | 6 | Line inversion mask (R9 positions) |
| sts_valid_o | output | 1 | Status strobe |
| sts_code_o | output | 2 | 0 ok, 1 not supported, 2 invalid |
| din_o | output | 1 | Serial data pin |
| dclk_o | output | 1 | Shift clock pin |
| dclr_o | output | 1 | Data clear pin |
| rclk_o | output | 1 | Buffer load pin |
| rclr_o | output | 1 | Buffer clear pin |
| ena_o | output | 1 | Enable pin |

## Verification
The first line phase of an accepted command appears in the cycle after the accepting edge. Each phase lasts exactly P cycles. The status strobe comes one cycle after the last phase, or in the cycle after acceptance when the command drives nothing, and ready rises one cycle after the status strobe. The reference model expands each command into a queue of per-cycle logical line vectors, in the same order of steps that the requirements describe. The bench pops one vector per cycle at the falling clock edge and compares it with all six pins. At the slot after the queue runs out, it checks the status strobe and code, and one cycle later it checks that ready has returned.

// File: rtl/srl_pkg.sv
package srl_pkg;
  localparam int unsigned NLINES = 6;
  localparam int unsigned NSTG   = 6;
  localparam int unsigned STG_W  = 3;

  // line bit positions in presence / inversion masks
  localparam int unsigned L_DIN  = 0;
  localparam int unsigned L_DCLK = 1;
  localparam int unsigned L_DCLR = 2;
  localparam int unsigned L_RCLK = 3;
  localparam int unsigned L_RCLR = 4;
  localparam int unsigned L_ENA  = 5;

  // fixed stage order walked by the sequencer
  localparam logic [STG_W-1:0] S_DCLR   = 3'd0;
  localparam logic [STG_W-1:0] S_RCLR   = 3'd1;
  localparam logic [STG_W-1:0] S_RCLK_A = 3'd2;
  localparam logic [STG_W-1:0] S_SHIFT  = 3'd3;
  localparam logic [STG_W-1:0] S_RCLK_B = 3'd4;
  localparam logic [STG_W-1:0] S_ENA    = 3'd5;

  typedef enum logic [2:0] {
    OP_WRITE     = 3'd0,
    OP_CLR_DATA  = 3'd1,
    OP_CLR_BUF   = 3'd2,
    OP_LOAD      = 3'd3,
    OP_CLR_ALL   = 3'd4,
    OP_ENA_ON    = 3'd5,
    OP_ENA_OFF   = 3'd6,
    OP_RSVD      = 3'd7
  } op_e;

  localparam logic [1:0] ST_OK    = 2'd0;
  localparam logic [1:0] ST_NSUP  = 2'd1;
  localparam logic [1:0] ST_INVAL = 2'd2;
endpackage

// File: rtl/srl_decode.sv
module srl_decode
  import srl_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned FILL_BITS = 32,
  parameter int unsigned NB_W      = 6,
  parameter int unsigned SC_W      = 6
) (
  input  logic              boot_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [NB_W-1:0]   nbits_i,
  input  logic              latch_i,
  input  logic [NLINES-1:0] present_i,
  output logic [NSTG-1:0]   mask_o,
  output logic [1:0]        sts_o,
  output logic [DATA_W-1:0] sh_data_o,
  output logic [SC_W-1:0]   sh_cnt_o,
  output logic              ena_lvl_o
);
  logic can_shift;
  assign can_shift = present_i[L_DIN] & present_i[L_DCLK];

  always_comb begin
    mask_o    = '0;
    sts_o     = ST_OK;
    sh_data_o = '0;
    sh_cnt_o  = '0;
    ena_lvl_o = 1'b0;
    if (boot_i) begin
      mask_o[S_DCLR] = present_i[L_DCLR];
      mask_o[S_RCLR] = present_i[L_RCLR];
      mask_o[S_ENA]  = present_i[L_ENA];
      ena_lvl_o      = 1'b1;
    end else begin
      case (op_e'(op_i))
        OP_WRITE: begin
          if (nbits_i > NB_W'(DATA_W)) sts_o = ST_INVAL;
          else if (!can_shift)         sts_o = ST_NSUP;
          else if (nbits_i != '0) begin
            mask_o[S_SHIFT]  = 1'b1;
            mask_o[S_RCLK_B] = latch_i & present_i[L_RCLK];
            sh_data_o        = data_i << (NB_W'(DATA_W) - nbits_i);
            sh_cnt_o         = SC_W'(nbits_i);
          end
        end
        OP_CLR_DATA: if (present_i[L_DCLR]) mask_o[S_DCLR] = 1'b1;   else sts_o = ST_NSUP;
        OP_CLR_BUF:  if (present_i[L_RCLR]) mask_o[S_RCLR] = 1'b1;   else sts_o = ST_NSUP;
        OP_LOAD:     if (present_i[L_RCLK]) mask_o[S_RCLK_A] = 1'b1; else sts_o = ST_NSUP;
        OP_CLR_ALL: begin
          if (present_i[L_DCLR]) begin
            mask_o[S_DCLR] = 1'b1;
            if (present_i[L_RCLR])      mask_o[S_RCLR]   = 1'b1;
            else if (present_i[L_RCLK]) mask_o[S_RCLK_A] = 1'b1;
            else if (can_shift) begin
              mask_o[S_SHIFT] = 1'b1;
              sh_cnt_o        = SC_W'(FILL_BITS);
            end else sts_o = ST_NSUP;
          end else if (can_shift) begin
            mask_o[S_SHIFT]  = 1'b1;
            mask_o[S_RCLK_B] = present_i[L_RCLK];
            sh_cnt_o         = SC_W'(FILL_BITS);
          end else sts_o = ST_NSUP;
        end
        OP_ENA_ON, OP_ENA_OFF: begin
          if (present_i[L_ENA]) begin
            mask_o[S_ENA] = 1'b1;
            ena_lvl_o     = (op_e'(op_i) == OP_ENA_ON);
          end else sts_o = ST_NSUP;
        end
        default: sts_o = ST_INVAL;
      endcase
    end
  end
endmodule

// File: rtl/srl_seq_core.sv
module srl_seq_core
  import srl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CW     = 4,
  parameter int unsigned SC_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NSTG-1:0]   mask_i,
  input  logic [DATA_W-1:0] sh_data_i,
  input  logic [SC_W-1:0]   sh_cnt_i,
  input  logic              ena_lvl_i,
  input  logic [CW-1:0]     pcyc_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [NLINES-1:0] lvl_o
);
  logic              busy_q, done_q, din_q, ena_q, enlvl_q;
  logic [NSTG-1:0]   mask_q, rest;
  logic [1:0]        ph_q, last_ph;
  logic [CW-1:0]     cnt_q, plen_q;
  logic [DATA_W-1:0] sreg_q;
  logic [SC_W-1:0]   left_q;
  logic [STG_W-1:0]  cur;
  logic              last_cnt, in_sh;

  // lowest pending stage runs first
  always_comb begin
    cur = '0;
    for (int i = NSTG - 1; i >= 0; i--) if (mask_q[i]) cur = STG_W'(i);
    rest = mask_q;
    rest[cur] = 1'b0;
  end

  assign last_cnt = (cnt_q == plen_q - 1'b1);
  assign last_ph  = (cur == S_SHIFT) ? 2'd2 : (cur == S_ENA) ? 2'd0 : 2'd1;
  assign in_sh    = busy_q && (cur == S_SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      mask_q  <= '0;
      ph_q    <= '0;
      cnt_q   <= '0;
      plen_q  <= CW'(1);
      sreg_q  <= '0;
      left_q  <= '0;
      din_q   <= 1'b0;
      ena_q   <= 1'b0;
      enlvl_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        mask_q  <= mask_i;
        ph_q    <= '0;
        cnt_q   <= '0;
        plen_q  <= (pcyc_i == '0) ? CW'(1) : pcyc_i;
        sreg_q  <= sh_data_i;
        left_q  <= sh_cnt_i;
        enlvl_q <= ena_lvl_i;
        if (mask_i == '0) done_q <= 1'b1;
        else              busy_q <= 1'b1;
      end else if (busy_q) begin
        if (cur == S_SHIFT) din_q <= sreg_q[DATA_W-1];
        if (cur == S_ENA)   ena_q <= enlvl_q;
        if (!last_cnt) cnt_q <= cnt_q + 1'b1;
        else begin
          cnt_q <= '0;
          if (ph_q != last_ph) ph_q <= ph_q + 1'b1;
          else begin
            ph_q <= '0;
            if (cur == S_SHIFT && left_q > SC_W'(1)) begin
              left_q <= left_q - 1'b1;
              sreg_q <= {sreg_q[DATA_W-2:0], 1'b0};
            end else begin
              mask_q <= rest;
              if (rest == '0) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
              end
            end
          end
        end
      end
    end
  end

  assign lvl_o[L_DIN]  = in_sh ? sreg_q[DATA_W-1] : din_q;
  assign lvl_o[L_DCLK] = in_sh && (ph_q == 2'd1);
  assign lvl_o[L_DCLR] = busy_q && (cur == S_DCLR) && (ph_q == 2'd0);
  assign lvl_o[L_RCLK] = busy_q && ((cur == S_RCLK_A) || (cur == S_RCLK_B)) && (ph_q == 2'd0);
  assign lvl_o[L_RCLR] = busy_q && (cur == S_RCLR) && (ph_q == 2'd0);
  assign lvl_o[L_ENA]  = (busy_q && cur == S_ENA) ? enlvl_q : ena_q;

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/srl_pin_drv.sv
module srl_pin_drv #(
  parameter int unsigned N = 6
) (
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] present_i,
  input  logic [N-1:0] invert_i,
  output logic [N-1:0] pin_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    assign pin_o[g] = (lvl_i[g] & present_i[g]) ^ invert_i[g];
  end
endmodule

// File: rtl/srl_line_seq.sv
module srl_line_seq
  import srl_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CW        = 4,
  parameter int unsigned FILL_BITS = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cmd_valid_i,
  output logic                        cmd_ready_o,
  input  logic [2:0]                  cmd_op_i,
  input  logic [DATA_W-1:0]           cmd_data_i,
  input  logic [$clog2(DATA_W+1)-1:0] cmd_nbits_i,
  input  logic                        cmd_latch_i,
  input  logic [CW-1:0]               pulse_cyc_i,
  input  logic [5:0]                  line_present_i,
  input  logic [5:0]                  line_invert_i,
  output logic                        sts_valid_o,
  output logic [1:0]                  sts_code_o,
  output logic                        din_o,
  output logic                        dclk_o,
  output logic                        dclr_o,
  output logic                        rclk_o,
  output logic                        rclr_o,
  output logic                        ena_o
);
  localparam int unsigned NB_W   = $clog2(DATA_W + 1);
  localparam int unsigned SH_MAX = (DATA_W > FILL_BITS) ? DATA_W : FILL_BITS;
  localparam int unsigned SC_W   = $clog2(SH_MAX + 1);

  logic              boot_q, boot_run_q, start, busy, done;
  logic [1:0]        sts_q, dec_sts;
  logic [NSTG-1:0]   dec_mask;
  logic [DATA_W-1:0] dec_data;
  logic [SC_W-1:0]   dec_cnt;
  logic              dec_ena;
  logic [NLINES-1:0] lvl, pins;

  assign cmd_ready_o = !boot_q && !busy && !done;
  assign start       = boot_q || (cmd_valid_i && cmd_ready_o);

  srl_decode #(.DATA_W(DATA_W), .FILL_BITS(FILL_BITS), .NB_W(NB_W), .SC_W(SC_W)) u_dec (
    .boot_i    (boot_q),
    .op_i      (cmd_op_i),
    .data_i    (cmd_data_i),
    .nbits_i   (cmd_nbits_i),
    .latch_i   (cmd_latch_i),
    .present_i (line_present_i),
    .mask_o    (dec_mask),
    .sts_o     (dec_sts),
    .sh_data_o (dec_data),
    .sh_cnt_o  (dec_cnt),
    .ena_lvl_o (dec_ena)
  );

  srl_seq_core #(.DATA_W(DATA_W), .CW(CW), .SC_W(SC_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .mask_i    (dec_mask),
    .sh_data_i (dec_data),
    .sh_cnt_i  (dec_cnt),
    .ena_lvl_i (dec_ena),
    .pcyc_i    (pulse_cyc_i),
    .busy_o    (busy),
    .done_o    (done),
    .lvl_o     (lvl)
  );

  srl_pin_drv #(.N(NLINES)) u_drv (
    .lvl_i     (lvl),
    .present_i (line_present_i),
    .invert_i  (line_invert_i),
    .pin_o     (pins)
  );

  // start-up sequence fires on the first edge after reset and reports nothing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q     <= 1'b1;
      boot_run_q <= 1'b0;
      sts_q      <= ST_OK;
    end else begin
      if (boot_q) begin
        boot_q     <= 1'b0;
        boot_run_q <= 1'b1;
      end else if (done) boot_run_q <= 1'b0;
      if (start) sts_q <= dec_sts;
    end
  end

  assign sts_valid_o = done && !boot_run_q;
  assign sts_code_o  = sts_valid_o ? sts_q : ST_OK;

  assign din_o  = pins[L_DIN];
  assign dclk_o = pins[L_DCLK];
  assign dclr_o = pins[L_DCLR];
  assign rclk_o = pins[L_RCLK];
  assign rclr_o = pins[L_RCLR];
  assign ena_o  = pins[L_ENA];
endmodule

// File: rtl/srl_line_seq_chk.sv
module srl_line_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic       cmd_ready_o,
  input logic       sts_valid_o,
  input logic [1:0] sts_code_o,
  input logic [5:0] line_invert_i,
  input logic       din_o,
  input logic       dclk_o,
  input logic       dclr_o,
  input logic       rclk_o,
  input logic       rclr_o,
  input logic       ena_o
);
  logic [5:0] lv;
  assign lv = {ena_o, rclr_o, rclk_o, dclr_o, dclk_o, din_o} ^ line_invert_i;

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lv[4:1]));

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (lv[4:1] == 4'b0000));

  a_r12_sts_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_valid_o |=> !sts_valid_o);

  a_r12_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);

  a_r12_no_ready_sts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_valid_o |-> !cmd_ready_o);

  a_r13_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_valid_o |-> (sts_code_o != 2'd3));

  a_r2_din_stable_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lv[1] && $stable(line_invert_i)) |-> $stable(din_o));

  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ready_o && !cmd_valid_i) |=> ($stable(ena_o) && $stable(din_o)));
endmodule

bind srl_line_seq srl_line_seq_chk u_chk (.*);

// File: tb/srl_line_seq_tb.sv
module srl_line_seq_tb;
  localparam int CLK_P = 10;
  localparam int DW    = 32;
  localparam int CW    = 4;
  localparam int FILL  = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = '0;
  logic [DW-1:0] cmd_data = '0;
  logic [5:0]    cmd_nbits = '0;
  logic          cmd_latch = 1'b0;
  logic [CW-1:0] pcyc = '0;
  logic [5:0]    pres = '1;
  logic [5:0]    inv = '0;
  logic          sts_valid;
  logic [1:0]    sts_code;
  logic          din, dclk, dclr, rclk, rclr, ena;

  int n_chk = 0;
  int n_fail = 0;
  logic [5:0] q[$];
  logic m_din = 1'b0;
  logic m_ena = 1'b0;
  int plen = 1;

  always #(CLK_P/2) clk = ~clk;

  srl_line_seq #(.DATA_W(DW), .CW(CW), .FILL_BITS(FILL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_data_i(cmd_data), .cmd_nbits_i(cmd_nbits),
    .cmd_latch_i(cmd_latch), .pulse_cyc_i(pcyc), .line_present_i(pres),
    .line_invert_i(inv), .sts_valid_o(sts_valid), .sts_code_o(sts_code),
    .din_o(din), .dclk_o(dclk), .dclr_o(dclr), .rclk_o(rclk), .rclr_o(rclr), .ena_o(ena)
  );

  function automatic logic [5:0] pins();
    return {ena, rclr, rclk, dclr, dclk, din};
  endfunction

  function automatic logic [5:0] bv();
    return {m_ena, 4'b0000, m_din};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ph(logic [5:0] v);
    for (int i = 0; i < plen; i++) q.push_back(v);
  endtask

  task automatic m_pulse(int idx);
    logic [5:0] v;
    v = bv();
    v[idx] = 1'b1;
    ph(v);
    ph(bv());
  endtask

  task automatic m_shift(logic [31:0] d, int n);
    for (int i = n - 1; i >= 0; i--) begin
      m_din = d[i];
      ph(bv());
      ph(bv() | 6'b000010);
      ph(bv());
    end
  endtask

  task automatic m_ena_set(logic l);
    m_ena = l;
    ph(bv());
  endtask

  // reference: per-cycle logical line vectors for one command
  task automatic model_cmd(logic [2:0] op, logic [31:0] d, int nb, logic al, output int code);
    bit sh;
    sh = pres[0] && pres[1];
    code = 0;
    case (op)
      3'd0: if (nb > DW) code = 2;
            else if (!sh) code = 1;
            else if (nb > 0) begin
              m_shift(d, nb);
              if (al && pres[3]) m_pulse(3);
            end
      3'd1: if (pres[2]) m_pulse(2); else code = 1;
      3'd2: if (pres[4]) m_pulse(4); else code = 1;
      3'd3: if (pres[3]) m_pulse(3); else code = 1;
      3'd4: if (pres[2]) begin
              m_pulse(2);
              if (pres[4]) m_pulse(4);
              else if (pres[3]) m_pulse(3);
              else if (sh) m_shift(32'h0, FILL);
              else code = 1;
            end else if (sh) begin
              m_shift(32'h0, FILL);
              if (pres[3]) m_pulse(3);
            end else code = 1;
      3'd5, 3'd6: if (pres[5]) m_ena_set(op == 3'd5); else code = 1;
      default: code = 2;
    endcase
  endtask

  task automatic drain(string req, int code, logic want_sts);
    logic [5:0] v;
    while (q.size() > 0) begin
      v = q.pop_front();
      chk(req, pins(), v ^ inv);
      chk(req, {cmd_ready, sts_valid}, 0);
      @(negedge clk);
    end
    chk(req, pins(), bv() ^ inv);
    chk(req, sts_valid, want_sts);
    if (want_sts) chk(req, sts_code, code);
    chk(req, cmd_ready, 0);
    @(negedge clk);
    chk(req, cmd_ready, 1);
    chk(req, sts_valid, 0);
    chk(req, pins(), bv() ^ inv);
  endtask

  task automatic run(string req, logic [2:0] op, logic [31:0] d, int nb, logic al, int pc);
    int code;
    q.delete();
    plen = (pc == 0) ? 1 : pc;
    model_cmd(op, d, nb, al, code);
    chk(req, cmd_ready, 1);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_data  = d;
    cmd_nbits = 6'(nb);
    cmd_latch = al;
    pcyc      = CW'(pc);
    @(negedge clk);
    cmd_valid = 1'b0;
    drain(req, code, 1'b1);
  endtask

  task automatic do_boot(logic [5:0] p, logic [5:0] iv, int pc);
    @(negedge clk);
    rst_n = 1'b0;
    pres = p;
    inv = iv;
    pcyc = CW'(pc);
    cmd_valid = 1'b0;
    m_din = 1'b0;
    m_ena = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset pins", pins(), iv);
    chk("R11 reset ready", {cmd_ready, sts_valid}, 0);
    rst_n = 1'b1;
    plen = (pc == 0) ? 1 : pc;
    q.delete();
    if (p[2]) m_pulse(2);
    if (p[4]) m_pulse(4);
    if (p[5]) m_ena_set(1'b1);
    @(negedge clk);
    drain("R11 startup", 0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // all lines present, no inversion
    do_boot(6'b111111, 6'b000000, 2);
    run("R1 write 0x8D n4", 3'd0, 32'h8D, 4, 1'b0, 1);
    run("R2 write 0xA5 n8", 3'd0, 32'hA5, 8, 1'b0, 2);
    run("R4 write autolatch", 3'd0, 32'h5A, 8, 1'b1, 3);
    run("R3 write n0", 3'd0, 32'hFF, 0, 1'b1, 1);
    run("R13 write n33", 3'd0, 32'hFF, 33, 1'b0, 1);
    run("R13 op7", 3'd7, 32'h0, 0, 1'b0, 1);
    run("R5 clear data", 3'd1, 32'h0, 0, 1'b0, 2);
    run("R5 clear buffer", 3'd2, 32'h0, 0, 1'b0, 2);
    run("R5 load", 3'd3, 32'h0, 0, 1'b0, 1);
    run("R8 disable", 3'd6, 32'h0, 0, 1'b0, 2);
    run("R8 enable", 3'd5, 32'h0, 0, 1'b0, 1);
    run("R6 full clear", 3'd4, 32'h0, 0, 1'b0, 1);
    run("R10 pulse len 0", 3'd0, 32'h3, 2, 1'b1, 0);
    run("R1 write full width", 3'd0, 32'hDEADBEEF, 32, 1'b0, 1);
    // no enable line, mixed inversion
    do_boot(6'b011111, 6'b101010, 1);
    run("R5 enable absent", 3'd5, 32'h0, 0, 1'b0, 1);
    run("R9 inverted write", 3'd0, 32'h5, 3, 1'b1, 2);
    run("R9 inverted clear", 3'd4, 32'h0, 0, 1'b0, 1);
    // no data clear, no buffer clear
    do_boot(6'b101011, 6'b000000, 1);
    run("R7 full clear fill", 3'd4, 32'h0, 0, 1'b0, 1);
    run("R5 clear data absent", 3'd1, 32'h0, 0, 1'b0, 1);
    run("R5 clear buffer absent", 3'd2, 32'h0, 0, 1'b0, 1);
    // no serial lines
    do_boot(6'b111100, 6'b000011, 1);
    run("R5 write absent", 3'd0, 32'hF, 4, 1'b1, 1);
    run("R5 write n0 absent", 3'd0, 32'h0, 0, 1'b0, 1);
    run("R6 full clear no serial", 3'd4, 32'h0, 0, 1'b0, 2);
    // no buffer load
    do_boot(6'b110111, 6'b000000, 1);
    run("R4 autolatch skipped", 3'd0, 32'h9, 4, 1'b1, 1);
    run("R5 load absent", 3'd3, 32'h0, 0, 1'b0, 1);
    // buffer clear absent: load substitutes
    do_boot(6'b101111, 6'b000000, 1);
    run("R6 full clear load fallback", 3'd4, 32'h0, 0, 1'b0, 2);
    // buffer clear and load absent: fill after data clear
    do_boot(6'b100111, 6'b000000, 1);
    run("R6 full clear fill after clear", 3'd4, 32'h0, 0, 1'b0, 1);
    // no data clear, no serial lines
    do_boot(6'b111000, 6'b000000, 1);
    run("R7 full clear unsupported", 3'd4, 32'h0, 0, 1'b0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule